// File: doc/BRIEF.md
# Discrete Sensor SPI Register Target

This block is the digital front of a 32-channel discrete input sensor. It acts as an SPI mode-0 target and is clocked by the system clock. It synchronizes the serial clock, chip select and data-in lines and decodes a register map. The analog comparators are outside the block: they drive the 32 channel states onto a parallel input bus, and they take the sensing-mode and threshold settings from the block's outputs.

Every transfer opens with a command byte: bit 7 is the direction and bits 6..0 are the register address. Data bytes follow, most significant byte first. A read captures its whole register value at the instant the command byte completes. A write takes effect only once its full width has arrived. Raising chip select drops whatever transfer is in progress.

Top module: `sensor_spi_target`

## Requirements
- R1: In the command byte, bit 7 = 1 selects a read and bit 7 = 0 selects a write; bits 6..0 give the register address.
- R2: MOSI is sampled on rising SCLK and MISO changes after falling SCLK, so the first data bit is valid before the first rising edge of the data phase; multi-byte values travel most significant byte first.
- R3: A 4-byte read of address 0x78 returns channel n at bit n of the word; all 32 bits are captured when the command byte completes, so status changes during the data phase do not appear.
- R4: 1-byte reads of 0x10, 0x12, 0x14 and 0x16 return channels 7..0, 15..8, 23..16 and 31..24 respectively, with the lowest channel at bit 0.
- R5: Address 0x02 is the control register: bit 0 drives test_en_o, bit 1 is the soft-reset bit, and bits 7..2 read as zero.
- R6: While control bit 1 is 1, the mode and threshold registers are held at zero and writes to them are ignored; after the bit is written back to 0 they hold zero until written again.
- R7: Address 0x04 is a 1-byte sensing-mode register; bit k drives sense_mode_o[k] (1 = supply-open, 0 = ground-open for channels 8k..8k+7), and bits 7..4 read as zero.
- R8: Addresses 0x3A (ground-open) and 0x3C (supply-open) are 16-bit registers holding hysteresis in the high byte and threshold center in the low byte; they drive gnd_thr_o and sup_thr_o and read back in 2 bytes.
- R9: A write commits only when its full width (1 byte for 0x02 and 0x04, 2 bytes for 0x3A and 0x3C) has been received; a transfer cut short by chip select rising changes nothing, and bytes beyond the width are ignored.
- R10: Reads of unmapped addresses return zero; writes to unmapped addresses and to the status addresses change no register or output.
- R11: After reset all registers read zero, all setting outputs are zero and miso is low.
- R12: miso is low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI serial clock (mode 0) |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data in |
| miso | output | 1 | SPI data out |
| chan_status | input | 32 | Channel states from the comparators, channel n at bit n |
| test_en_o | output | 1 | Test enable from control bit 0 |
| sense_mode_o | output | 4 | Per-bank sensing mode |
| gnd_thr_o | output | 16 | Ground-open threshold {hysteresis, center} |
| sup_thr_o | output | 16 | Supply-open threshold {hysteresis, center} |

## Verification
The assertions check four properties on every cycle. miso stays quiet while chip select is idle. No write commit happens with chip select high. The setting outputs move only on a commit or a soft reset. The soft-reset bit holds the mode and threshold registers at zero. Address decode, byte order, the bit order of the status word and of each group, and the capture instant of the status word can only be shown by the bench's transfers. Aborted and over-long frames are likewise shown only by transfers that finish early or run past the register width, followed by a readback.

// File: rtl/sensor_spi_pkg.sv
package sensor_spi_pkg;
    localparam int CHANNELS  = 32;
    localparam int BANKS     = CHANNELS / 8;
    localparam int MAX_BYTES = CHANNELS / 8;
    localparam int WORD_W    = 8 * MAX_BYTES;

    localparam logic [6:0] ADDR_CTRL = 7'h02;
    localparam logic [6:0] ADDR_MODE = 7'h04;
    localparam logic [6:0] ADDR_GTHR = 7'h3A;
    localparam logic [6:0] ADDR_STHR = 7'h3C;
    localparam logic [6:0] ADDR_WORD = 7'h78;
    localparam logic [3:0] GRP_PAGE  = 4'h2;   // 0x10..0x17, even addresses

    typedef enum logic {PH_CMD, PH_DATA} phase_e;

    typedef struct packed {
        logic       rd;
        logic [6:0] addr;
    } cmd_t;

    typedef struct packed {
        logic srst;
        logic test_en;
    } ctrl_t;

    // bytes a write to this address must carry before it commits
    function automatic logic [2:0] wr_bytes(input logic [6:0] a);
        case (a)
            ADDR_CTRL, ADDR_MODE: return 3'd1;
            ADDR_GTHR, ADDR_STHR: return 3'd2;
            default:              return 3'd0;
        endcase
    endfunction
endpackage

// File: rtl/sensor_spi_sync.sv
module sensor_spi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_idle,
    output logic mosi_s
);
    // {sclk, cs_n, mosi}
    localparam logic [2:0] IDLE_VAL = 3'b010;
    logic [2:0] chain [STAGES];
    logic       sclk_d;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= IDLE_VAL;
        else     chain[0] <= {sclk, cs_n, mosi};
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= IDLE_VAL;
            else     chain[g] <= chain[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b0;
        else     sclk_d <= chain[STAGES-1][2];
    end

    assign cs_idle   = chain[STAGES-1][1];
    assign mosi_s    = chain[STAGES-1][0];
    assign sclk_rise =  chain[STAGES-1][2] & ~sclk_d & ~cs_idle;
    assign sclk_fall = ~chain[STAGES-1][2] &  sclk_d & ~cs_idle;
endmodule

// File: rtl/sensor_spi_regs.sv
module sensor_spi_regs
    import sensor_spi_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [6:0]           wr_addr,
    input  logic [15:0]          wr_data,
    input  logic [6:0]           rd_addr,
    input  logic [CHANNELS-1:0]  chan_status,
    output logic [WORD_W-1:0]    rd_word,
    output logic                 srst,
    output logic                 test_en,
    output logic [BANKS-1:0]     sense_mode,
    output logic [15:0]          gthr,
    output logic [15:0]          sthr
);
    ctrl_t               ctrl_q;
    logic [CHANNELS-1:0] chan_q;

    always_ff @(posedge clk) begin
        if (rst) chan_q <= '0;
        else     chan_q <= chan_status;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            sense_mode <= '0;
            gthr       <= '0;
            sthr       <= '0;
        end else begin
            if (wr_en && wr_addr == ADDR_CTRL)
                ctrl_q <= ctrl_t'(wr_data[1:0]);
            if (ctrl_q.srst) begin
                sense_mode <= '0;
                gthr       <= '0;
                sthr       <= '0;
            end else if (wr_en) begin
                case (wr_addr)
                    ADDR_MODE: sense_mode <= wr_data[BANKS-1:0];
                    ADDR_GTHR: gthr       <= wr_data;
                    ADDR_STHR: sthr       <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    assign srst    = ctrl_q.srst;
    assign test_en = ctrl_q.test_en;

    // read value, left-aligned so the first byte sent sits at the top
    always_comb begin
        rd_word = '0;
        if (rd_addr[6:3] == GRP_PAGE && !rd_addr[0])
            rd_word[WORD_W-1 -: 8] = chan_q[rd_addr[2:1]*8 +: 8];
        else begin
            case (rd_addr)
                ADDR_CTRL: rd_word[WORD_W-1 -: 8]  = {6'b0, ctrl_q};
                ADDR_MODE: rd_word[WORD_W-1 -: 8]  = {{(8-BANKS){1'b0}}, sense_mode};
                ADDR_GTHR: rd_word[WORD_W-1 -: 16] = gthr;
                ADDR_STHR: rd_word[WORD_W-1 -: 16] = sthr;
                ADDR_WORD: rd_word                 = chan_q;
                default:   rd_word                 = '0;
            endcase
        end
    end
endmodule

// File: rtl/sensor_spi_target.sv
module sensor_spi_target
    import sensor_spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sclk,
    input  logic                cs_n,
    input  logic                mosi,
    output logic                miso,
    input  logic [CHANNELS-1:0] chan_status,
    output logic                test_en_o,
    output logic [BANKS-1:0]    sense_mode_o,
    output logic [15:0]         gnd_thr_o,
    output logic [15:0]         sup_thr_o
);
    logic sclk_rise, sclk_fall, cs_idle, mosi_s;

    sensor_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_idle(cs_idle), .mosi_s(mosi_s)
    );

    phase_e            phase;
    logic [2:0]        bit_cnt;
    logic [6:0]        rx_sr;
    logic [7:0]        rx_byte;
    cmd_t              cmd;
    logic [2:0]        byte_idx;
    logic [7:0]        hold_byte;
    logic [WORD_W-1:0] tx_sr;
    logic [WORD_W-1:0] rd_word;
    logic              shift_ok;
    logic              miso_q;
    logic              byte_done;
    logic              wr_en;
    logic              srst;

    assign rx_byte   = {rx_sr, mosi_s};
    assign byte_done = sclk_rise && bit_cnt == 3'd7;
    assign wr_en     = byte_done && phase == PH_DATA && !cmd.rd
                       && wr_bytes(cmd.addr) != 3'd0
                       && (byte_idx + 3'd1) == wr_bytes(cmd.addr);

    sensor_spi_regs u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(cmd.addr), .wr_data({hold_byte, rx_byte}),
        .rd_addr(rx_byte[6:0]), .chan_status(chan_status),
        .rd_word(rd_word), .srst(srst), .test_en(test_en_o),
        .sense_mode(sense_mode_o), .gthr(gnd_thr_o), .sthr(sup_thr_o)
    );

    always_ff @(posedge clk) begin
        if (rst || cs_idle) begin
            phase     <= PH_CMD;
            bit_cnt   <= '0;
            rx_sr     <= '0;
            cmd       <= '0;
            byte_idx  <= '0;
            hold_byte <= '0;
            tx_sr     <= '0;
            shift_ok  <= 1'b0;
            miso_q    <= 1'b0;
        end else begin
            miso_q <= (phase == PH_DATA && cmd.rd) ? tx_sr[WORD_W-1] : 1'b0;
            if (sclk_rise) begin
                rx_sr   <= rx_byte[6:0];
                bit_cnt <= bit_cnt + 3'd1;
                if (phase == PH_DATA) shift_ok <= 1'b1;
                if (byte_done) begin
                    if (phase == PH_CMD) begin
                        cmd      <= cmd_t'(rx_byte);
                        phase    <= PH_DATA;
                        tx_sr    <= rx_byte[7] ? rd_word : '0;
                        shift_ok <= 1'b0;
                    end else begin
                        hold_byte <= rx_byte;
                        if (byte_idx != 3'd7) byte_idx <= byte_idx + 3'd1;
                    end
                end
            end else if (sclk_fall && phase == PH_DATA && shift_ok) begin
                tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
            end
        end
    end

    assign miso = miso_q;
endmodule

// File: rtl/sensor_spi_target_chk.sv
module sensor_spi_target_chk (
    input logic        clk,
    input logic        rst,
    input logic        cs_idle,
    input logic        miso,
    input logic        wr_en,
    input logic        srst,
    input logic        test_en,
    input logic [3:0]  sense_mode,
    input logic [15:0] gthr,
    input logic [15:0] sthr
);
    // R12
    miso_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_idle && $past(cs_idle)) |-> !miso);

    // R9
    idle_no_commit_chk: assert property (@(posedge clk) disable iff (rst)
        cs_idle |-> !wr_en);

    // R6
    srst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (srst && $past(srst)) |-> (sense_mode == '0 && gthr == '0 && sthr == '0));

    // R10
    settings_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !srst) |=> $stable({test_en, sense_mode, gthr, sthr}));
endmodule

bind sensor_spi_target sensor_spi_target_chk u_chk (
    .clk(clk), .rst(rst), .cs_idle(cs_idle), .miso(miso), .wr_en(wr_en),
    .srst(srst), .test_en(test_en_o), .sense_mode(sense_mode_o),
    .gthr(gnd_thr_o), .sthr(sup_thr_o)
);

// File: tb/sensor_spi_target_test.sv
`timescale 1ns/1ps
module sensor_spi_target_test;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic [31:0] chan_status = '0;
    logic        test_en_o;
    logic [3:0]  sense_mode_o;
    logic [15:0] gnd_thr_o, sup_thr_o;

    int n_chk = 0;
    int n_bad = 0;
    bit reported = 0;

    always #2 clk = ~clk;

    sensor_spi_target uut (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .chan_status(chan_status), .test_en_o(test_en_o),
        .sense_mode_o(sense_mode_o), .gnd_thr_o(gnd_thr_o), .sup_thr_o(sup_thr_o)
    );

    task automatic wait_half();
        repeat (HALF) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
        $finish;
    endtask

    // shifts nbits of tx (first bit at bit 39), data out sampled before each rising edge
    task automatic spi_bits(input logic [39:0] tx, input int nbits, output logic [39:0] rx);
        rx = '0;
        cs_n = 1'b0;
        wait_half();
        for (int i = 0; i < nbits; i++) begin
            mosi = tx[39-i];
            wait_half();
            rx[39-i] = miso;
            sclk = 1'b1;
            wait_half();
            sclk = 1'b0;
        end
        wait_half();
        cs_n = 1'b1;
        wait_half();
        wait_half();
    endtask

    task automatic wr8(input logic [6:0] a, input logic [7:0] d);
        logic [39:0] rx;
        spi_bits({1'b0, a, d, 24'h0}, 16, rx);
    endtask

    task automatic wr16(input logic [6:0] a, input logic [15:0] d);
        logic [39:0] rx;
        spi_bits({1'b0, a, d, 16'h0}, 24, rx);
    endtask

    task automatic rd(input logic [6:0] a, input int nbytes, output logic [31:0] v);
        logic [39:0] rx;
        spi_bits({1'b1, a, 32'h0}, 8 + 8 * nbytes, rx);
        v = rx[31:0];
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R11 test_en", {31'b0, test_en_o}, 0);
        check("R11 mode", {28'b0, sense_mode_o}, 0);
        check("R11 thresholds", {gnd_thr_o, sup_thr_o}, 0);
        check("R11 miso", {31'b0, miso}, 0);
        rd(7'h02, 1, v);
        check("R11 ctrl read", v, 0);
        rd(7'h3C, 2, v);
        check("R11 sup thr read", v, 0);
    endtask

    task automatic t_ctrl_mode();
        logic [31:0] v;
        wr8(7'h02, 8'hFD);                   // bit0 set, bit1 clear
        check("R5 test_en_o", {31'b0, test_en_o}, 1);
        rd(7'h02, 1, v);
        check("R1 R5 ctrl readback", v, 32'h0100_0000);
        wr8(7'h02, 8'h00);
        check("R5 test_en cleared", {31'b0, test_en_o}, 0);
        wr8(7'h04, 8'hF6);
        check("R7 sense_mode_o", {28'b0, sense_mode_o}, 32'h6);
        rd(7'h04, 1, v);
        check("R7 mode readback", v, 32'h0600_0000);
    endtask

    task automatic t_thresholds();
        logic [31:0] v;
        wr16(7'h3A, 16'h0206);
        wr16(7'h3C, 16'h0A13);
        check("R8 R2 gnd_thr_o", {16'b0, gnd_thr_o}, 32'h0206);
        check("R8 R2 sup_thr_o", {16'b0, sup_thr_o}, 32'h0A13);
        rd(7'h3C, 2, v);
        check("R8 R2 sup readback", v, 32'h0A13_0000);
        rd(7'h3A, 2, v);
        check("R8 gnd readback", v, 32'h0206_0000);
    endtask

    task automatic t_status();
        logic [31:0] v;
        chan_status = 32'hA1B2_C3D4;
        repeat (4) @(posedge clk);
        rd(7'h78, 4, v);
        check("R3 R2 status word", v, 32'hA1B2_C3D4);
        rd(7'h10, 1, v);
        check("R4 group 7..0", v, 32'hD400_0000);
        rd(7'h12, 1, v);
        check("R4 group 15..8", v, 32'hC300_0000);
        rd(7'h14, 1, v);
        check("R4 group 23..16", v, 32'hB200_0000);
        rd(7'h16, 1, v);
        check("R4 group 31..24", v, 32'hA100_0000);
        chan_status = 32'h8000_0001;
        repeat (4) @(posedge clk);
        rd(7'h78, 4, v);
        check("R3 channel n at bit n", v, 32'h8000_0001);
    endtask

    task automatic t_coherent();
        logic [31:0] v;
        chan_status = 32'h1234_5678;
        repeat (4) @(posedge clk);
        fork
            rd(7'h78, 4, v);
            begin
                repeat (HALF + 13 * 2 * HALF) @(posedge clk);
                chan_status = 32'hFFFF_0000;
            end
        join
        check("R3 captured at command end", v, 32'h1234_5678);
        check("R12 miso idle", {31'b0, miso}, 0);
    endtask

    task automatic t_abort();
        logic [39:0] rx;
        spi_bits({1'b0, 7'h3C, 16'hBEEF, 16'h0}, 20, rx);
        check("R9 partial 16-bit write", {16'b0, sup_thr_o}, 32'h0A13);
        spi_bits({1'b0, 7'h02, 8'hFF, 24'h0}, 12, rx);
        check("R9 partial byte write", {31'b0, test_en_o}, 0);
        spi_bits({1'b0, 7'h04, 8'h05, 8'h0A, 16'h0}, 24, rx);
        check("R9 extra byte ignored", {28'b0, sense_mode_o}, 32'h5);
        wr8(7'h02, 8'h01);
        check("R9 full frame after abort", {31'b0, test_en_o}, 1);
        wr8(7'h02, 8'h00);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr8(7'h20, 8'hFF);
        rd(7'h20, 1, v);
        check("R10 unmapped read", v, 0);
        wr16(7'h78, 16'hFFFF);
        wr8(7'h10, 8'hFF);
        check("R10 status write ignored", {test_en_o, 3'b0, sense_mode_o, 8'h0, gnd_thr_o}, 32'h0500_0206);
        rd(7'h7F, 2, v);
        check("R10 unmapped 2-byte read", v, 0);
    endtask

    task automatic t_soft_reset();
        logic [31:0] v;
        wr8(7'h02, 8'h02);
        check("R6 cleared on set", {sense_mode_o, gnd_thr_o, sup_thr_o}, 0);
        wr16(7'h3A, 16'h0408);
        check("R6 write blocked", {16'b0, gnd_thr_o}, 0);
        wr8(7'h02, 8'h00);
        check("R6 zero after release", {sense_mode_o, gnd_thr_o, sup_thr_o}, 0);
        wr16(7'h3A, 16'h0408);
        rd(7'h3A, 2, v);
        check("R6 writable again", v, 32'h0408_0000);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        repeat (5) @(posedge clk);
        #1;
        t_reset();
        t_ctrl_mode();
        t_thresholds();
        t_status();
        t_coherent();
        t_abort();
        t_unmapped();
        t_soft_reset();
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule